// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns the levels of a bank of general-purpose pins into a single interrupt request. Each pin is programmed on its own. It can be edge-sensitive or level-sensitive. An edge pin can fire on one chosen edge or on both edges. A level pin can fire on a chosen level, high or low. Every pin that fires sets a sticky raw status bit. A mask register selects which raw bits may reach the interrupt output. Software acknowledges an event by writing ones to a clear register.

The surrounding GPIO logic feeds the block with the already synchronised pin levels and the direction register. The block compares each pin with the copy registered on the previous cycle to find edges. Pins driven as outputs never produce edge events. A small register port with an eight-slot word address carries configuration writes and status reads. Reads are combinational.

Top module: `gpio_irq_detect`

## Requirements
- R1: The configuration registers read back the value last written. Address 0 is sense (bit = 1 selects level), address 1 is both-edges, address 2 is event and address 3 is mask. Addresses 6 and 7 read as zero.
- R2: For an edge-sense pin configured as an input (direction bit 0) with its both-edges bit at 1, any change of level sets that pin's raw bit. The new value can be read at address 4 in the cycle after the clock edge at which the change is seen.
- R3: For an edge-sense input pin with its both-edges bit at 0, a change sets the raw bit only when the new level equals the event bit. An event bit of 1 therefore selects rising edges and 0 selects falling edges.
- R4: For a level-sense pin, the raw bit is set on every clock edge at which the pin level equals its event bit, whatever the pin's direction. It therefore comes back right after a clear while the condition holds.
- R5: Raw status bits are sticky. A write to address 6 clears exactly the raw bits where the written data is 1 and leaves the others unchanged.
- R6: Address 5 reads raw status ANDed with the mask. `irqOut` is high exactly when that value is nonzero.
- R7: After reset all configuration registers and all raw status are 0, and `irqOut` is low.
- R8: An edge-sense pin whose direction bit is 1 (output) never sets its raw bit.
- R9: When a set condition and a clear write hit the same bit at the same clock edge, the bit ends up set.
- R10: Writes to the read-only status addresses 4 and 5, and to address 7, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinData | input | NUM_PINS | Synchronised pin levels |
| pinDir | input | NUM_PINS | Direction per pin, 1 = output |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | NUM_PINS | Register write data |
| regRdData | output | NUM_PINS | Combinational register read data |
| irqOut | output | 1 | Combined masked interrupt request |

## Verification
The bench uses the default of eight pins. Each pin gets a different pairing of sense, both-edges and event bits, so all eight detection variants run side by side in one configuration. It then drives every one of the 256 pin patterns in order, once with all pins as inputs and once with some pins as outputs. This covers every rising and falling transition in each mode and the effect of pin direction. After each pattern it clears all bits, which shows level re-assertion and the rule that a set beats a clear in the same cycle. Directed cases cover register readback, partial clears and writes to the read-only addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_SENSE  = 3'd0,
    SEL_BOTH   = 3'd1,
    SEL_EVENT  = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_RAW    = 3'd4,
    SEL_MASKED = 3'd5,
    SEL_CLEAR  = 3'd6,
    SEL_SPARE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrMask;
    logic wrClear;
  } cfgStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output cfgStrobe_t            strobe,
  output regSel_e               rdSel
);

  regSel_e addrSel;
  assign addrSel = regSel_e'(regAddr);
  assign rdSel   = addrSel;

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      unique case (addrSel)
        SEL_SENSE: strobe.wrSense = 1'b1;
        SEL_BOTH:  strobe.wrBoth  = 1'b1;
        SEL_EVENT: strobe.wrEvent = 1'b1;
        SEL_MASK:  strobe.wrMask  = 1'b1;
        SEL_CLEAR: strobe.wrClear = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinData,
  input  logic [NUM_PINS-1:0] pinDir,
  input  logic [NUM_PINS-1:0] wrData,
  input  cfgStrobe_t          strobe,
  input  regSel_e             rdSel,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] senseQ, bothQ, eventQ, maskQ;
  logic [NUM_PINS-1:0] rawQ, prevQ;
  logic [NUM_PINS-1:0] setVec, clrMask, maskedVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseQ <= '0;
      bothQ  <= '0;
      eventQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobe.wrSense) senseQ <= wrData;
      if (strobe.wrBoth)  bothQ  <= wrData;
      if (strobe.wrEvent) eventQ <= wrData;
      if (strobe.wrMask)  maskQ  <= wrData;
    end
  end

  // previous-cycle copy used for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= pinData;
  end

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      logic pinChg, levelHit, edgeHit, levelMatch;
      assign levelMatch = ~(pinData[i] ^ eventQ[i]);
      assign pinChg     = (pinData[i] ^ prevQ[i]) & ~pinDir[i];
      assign levelHit   = senseQ[i] & levelMatch;
      assign edgeHit    = ~senseQ[i] & pinChg & (bothQ[i] | levelMatch);
      assign setVec[i]  = levelHit | edgeHit;

      // R2: both-edges input pin toggling raises its status
      p_both_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
        (!senseQ[i] && bothQ[i] && !pinDir[i] && (pinData[i] != prevQ[i])) |=> rawQ[i]);
      // R4: level match raises status even across a clear
      p_level_set_r4: assert property (@(posedge clk) disable iff (!rstN)
        (senseQ[i] && (pinData[i] == eventQ[i])) |=> rawQ[i]);
      // R8: output-direction edge pin never raises status
      p_output_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
        (!senseQ[i] && pinDir[i] && !rawQ[i]) |=> !rawQ[i]);
    end
  endgenerate

  assign clrMask = strobe.wrClear ? wrData : '0;

  // set takes priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= (rawQ & ~clrMask) | setVec;
  end

  assign maskedVec = rawQ & maskQ;
  assign irqOut    = |maskedVec;

  always_comb begin
    unique case (rdSel)
      SEL_SENSE:  rdData = senseQ;
      SEL_BOTH:   rdData = bothQ;
      SEL_EVENT:  rdData = eventQ;
      SEL_MASK:   rdData = maskQ;
      SEL_RAW:    rdData = rawQ;
      SEL_MASKED: rdData = maskedVec;
      default:    rdData = '0;
    endcase
  end

  // R5: bits not being cleared stay set
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(rawQ & ~clrMask)) |=> ((rawQ & $past(rawQ & ~clrMask)) == $past(rawQ & ~clrMask)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinData,
  input  logic [NUM_PINS-1:0]   pinDir,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_PINS-1:0]   regWrData,
  output logic [NUM_PINS-1:0]   regRdData,
  output logic                  irqOut
);

  cfgStrobe_t strobe;
  regSel_e    rdSel;

  gpio_irq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinData (pinData),
    .pinDir  (pinDir),
    .wrData  (regWrData),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );

  // R6: the request is low whenever the mask-qualified status reads zero
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_MASKED && regRdData == '0) |-> !irqOut);

endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinData, pinDir, regWrData, regRdData;
  logic       regWrEn, irqOut;
  logic [2:0] regAddr;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 0;

  logic [7:0] senseM, bothM, eventM, maskM, rawM, prevM;

  always #5 clk = ~clk;

  gpio_irq_detect dut (
    .clk(clk), .rstN(rstN), .pinData(pinData), .pinDir(pinDir),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkReg(input logic [2:0] addr, input logic [7:0] exp, input string tag);
    regAddr = addr;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic checkIrq(input string tag);
    check(tag, {7'd0, irqOut}, {7'd0, |(rawM & maskM)});
  endtask

  // one clock with a model update computed from the requirements
  task automatic step(input logic [7:0] pd, input logic [7:0] dir,
                      input bit wr, input logic [2:0] addr, input logic [7:0] wd);
    logic [7:0] chg, setv, clr;
    @(negedge clk);
    pinData = pd; pinDir = dir; regWrEn = wr; regAddr = addr; regWrData = wd;
    chg = (pd ^ prevM) & ~dir;
    for (int b = 0; b < 8; b++) begin
      if (senseM[b]) setv[b] = (pd[b] == eventM[b]);
      else           setv[b] = chg[b] && (bothM[b] || (pd[b] == eventM[b]));
    end
    clr  = (wr && addr == 3'd6) ? wd : 8'h00;
    rawM = (rawM & ~clr) | setv;
    prevM = pd;
    if (wr) begin
      case (addr)
        3'd0: senseM = wd;
        3'd1: bothM  = wd;
        3'd2: eventM = wd;
        3'd3: maskM  = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pinData = 8'h00; pinDir = 8'h00;
    regWrEn = 1'b0; regAddr = 3'd0; regWrData = 8'h00;
    senseM = 0; bothM = 0; eventM = 0; maskM = 0; rawM = 0; prevM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R7 reset state
    for (int a = 0; a < 8; a++) checkReg(3'(a), 8'h00, "R7");
    check("R7 irq", {7'd0, irqOut}, 8'h00);

    // R1 readback
    step(8'h00, 8'h00, 1, 3'd0, 8'h96);
    step(8'h00, 8'h00, 1, 3'd1, 8'h3C);
    step(8'h00, 8'h00, 1, 3'd2, 8'hE1);
    step(8'h00, 8'h00, 1, 3'd3, 8'h5A);
    checkReg(3'd0, senseM, "R1");
    checkReg(3'd1, bothM, "R1");
    checkReg(3'd2, eventM, "R1");
    checkReg(3'd3, maskM, "R1");
    checkReg(3'd6, 8'h00, "R1");
    checkReg(3'd7, 8'h00, "R1");

    // R5 partial clear: all pins both-edge inputs
    step(8'h00, 8'h00, 1, 3'd0, 8'h00);
    step(8'h00, 8'h00, 1, 3'd1, 8'hFF);
    step(8'h00, 8'h00, 1, 3'd6, 8'hFF);
    step(8'hFF, 8'h00, 0, 3'd0, 8'h00);
    checkReg(3'd4, 8'hFF, "R2");
    step(8'hFF, 8'h00, 1, 3'd6, 8'h0F);
    checkReg(3'd4, 8'hF0, "R5");
    step(8'hFF, 8'h00, 1, 3'd6, 8'h00);
    checkReg(3'd4, 8'hF0, "R5");

    // R10 writes to status and spare addresses do nothing
    step(8'hFF, 8'h00, 1, 3'd4, 8'h00);
    step(8'hFF, 8'h00, 1, 3'd5, 8'hFF);
    step(8'hFF, 8'h00, 1, 3'd7, 8'hFF);
    checkReg(3'd4, 8'hF0, "R10");
    checkReg(3'd0, 8'h00, "R10");
    checkReg(3'd3, 8'h5A, "R10");

    // R9 set and clear same edge
    step(8'hFF, 8'h00, 1, 3'd6, 8'hFF);
    step(8'hFE, 8'h00, 1, 3'd6, 8'hFF);
    checkReg(3'd4, 8'h01, "R9");
    check("R9 model", rawM, 8'h01);

    // sweep: per-pin mixture of sense, both-edges and event
    step(pinData, 8'h00, 1, 3'd0, 8'hAA);
    step(pinData, 8'h00, 1, 3'd1, 8'hCC);
    step(pinData, 8'h00, 1, 3'd2, 8'hF0);
    step(pinData, 8'h00, 1, 3'd3, 8'h69);
    step(pinData, 8'h00, 1, 3'd6, 8'hFF);
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] dir;
        dir = (d == 0) ? 8'h00 : 8'h3C;
        step(8'(v), dir, 0, 3'd0, 8'h00);
        checkReg(3'd4, rawM, "R2 R3 R4 R8");
        checkReg(3'd5, rawM & maskM, "R6");
        checkIrq("R6 irq");
        step(8'(v), dir, 1, 3'd6, 8'hFF);
        checkReg(3'd4, rawM, "R4 R5 R9");
        checkIrq("R6 irq after clear");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule